// File: doc/BRIEF.md
# Page Protection Abort Unit

This unit sits between a processor's address bus and its memory system. It checks each memory access against a small table of per-page permissions. When the access is not permitted, it raises an abort that the processor treats as a page fault. Each access carries three qualifiers: a read/write direction, a privilege indication (user or privileged) and a two-bit cycle-type code. The unit answers with an abort flag and a memory-enable flag in the same cycle.

The table lookup is needed only when the address stream breaks. A non-sequential cycle always reads the table and latches the entry it finds. A sequential cycle in the same page reuses that latched entry, which avoids both the lookup power and the lookup delay. Two cases force a fresh lookup on a sequential cycle: the address has moved into another page, or nothing has been latched since reset. The direction and privilege checks are always applied against the current access. The table is loaded through a single-entry register write port, and every entry starts out invalid.

Top module: `page_prot_abort`

## Requirements
- R1: After reset every table entry is invalid, so every access aborts until its page is programmed.
- R2: A write on the config port stores cfg_data_i into entry cfg_idx_i at the clock edge. In cfg_data_i, bit 2 is valid, bit 1 is write-allowed and bit 0 is user-allowed. The new entry is seen by accesses from the next cycle on.
- R3: An access whose entry has valid = 0 aborts, whatever its direction and mode.
- R4: A write (write_i = 1) to an entry with write-allowed = 0 aborts. A read of that entry is not refused on that account.
- R5: A user-mode access (priv_i = 0) to an entry with user-allowed = 0 aborts. A privileged access (priv_i = 1) is not refused on that account.
- R6: The cycle codes are 00 non-sequential, 01 sequential, 10 internal and 11 coprocessor. On codes 10 and 11, abort_o and mem_en_o are both 0.
- R7: A non-sequential cycle always checks against the current table contents and latches the entry it used.
- R8: A sequential cycle in the same page as the latched entry checks against the latched entry, so table writes made since that lookup have no effect on it. The latched entry survives internal and coprocessor cycles.
- R9: A sequential cycle does a fresh lookup in two cases: its page differs from the latched page, or no entry has been latched since reset.
- R10: mem_en_o is 1 exactly when the cycle is an access (code 00 or 01) and abort_o is 0. Both outputs respond combinationally within the access cycle.
- R11: The page index is the top PAGE_W bits of addr_i. The lower address bits have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Access address |
| write_i | input | 1 | 1 = write, 0 = read |
| priv_i | input | 1 | 1 = privileged mode, 0 = user mode |
| cyc_i | input | 2 | Cycle type code |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_idx_i | input | PAGE_W | Table entry to write |
| cfg_data_i | input | 3 | Entry bits {valid, write-allowed, user-allowed} |
| abort_o | output | 1 | Access refused |
| mem_en_o | output | 1 | Access granted to memory |

## Verification
The bench builds the unit with its default 16-bit address and 4-bit page index, which gives 16 pages of 4 KB. This makes every page, every one of the 8 entry encodings and every direction/mode pair small enough to sweep exhaustively. Each case is tried on non-sequential, sequential, internal and coprocessor cycles, at varied offsets within the page. A bench-side copy of the table and the latched entry lets it test the reuse rules directly. It rewrites a page after a lookup, crosses pages on a sequential cycle, and starts a sequential cycle straight after reset.

// File: rtl/ppa_pkg.sv
package ppa_pkg;

  typedef enum logic [1:0] {
    CYC_NSEQ  = 2'b00,
    CYC_SEQ   = 2'b01,
    CYC_IDLE  = 2'b10,
    CYC_COPRO = 2'b11
  } cyc_e;

  typedef struct packed {
    logic valid;
    logic wr_ok;
    logic usr_ok;
  } perm_t;

  localparam int unsigned PERM_W = $bits(perm_t);

  function automatic logic is_access(input logic [1:0] cyc);
    return (cyc == CYC_NSEQ) || (cyc == CYC_SEQ);
  endfunction

endpackage

// File: rtl/ppa_perm_table.sv
module ppa_perm_table
  import ppa_pkg::*;
#(
  parameter int unsigned PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PAGE_W-1:0] wr_idx_i,
  input  perm_t             wr_perm_i,
  input  logic [PAGE_W-1:0] rd_idx_i,
  output perm_t             rd_perm_o
);

  localparam int unsigned PAGES = 1 << PAGE_W;

  perm_t rows [PAGES];

  for (genvar g = 0; g < PAGES; g++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rows[g] <= '0;
      end else if (wr_en_i && (wr_idx_i == PAGE_W'(g))) begin
        rows[g] <= wr_perm_i;
      end
    end
  end

  assign rd_perm_o = rows[rd_idx_i];

  assert_cfg_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rows[$past(wr_idx_i)] == $past(wr_perm_i));

endmodule

// File: rtl/ppa_verdict_hold.sv
module ppa_verdict_hold
  import ppa_pkg::*;
#(
  parameter int unsigned PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cyc_i,
  input  logic [PAGE_W-1:0] page_i,
  input  perm_t             tbl_perm_i,
  output perm_t             use_perm_o,
  output logic              lookup_o
);

  perm_t             hold_perm_q;
  logic [PAGE_W-1:0] hold_page_q;
  logic              hold_vld_q;
  logic              seq_miss;

  // sequential cycles only skip the table when the latched page still applies
  assign seq_miss = !hold_vld_q || (page_i != hold_page_q);
  assign lookup_o = (cyc_i == CYC_NSEQ) || ((cyc_i == CYC_SEQ) && seq_miss);
  assign use_perm_o = lookup_o ? tbl_perm_i : hold_perm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_perm_q <= '0;
      hold_page_q <= '0;
      hold_vld_q  <= 1'b0;
    end else if (lookup_o) begin
      hold_perm_q <= tbl_perm_i;
      hold_page_q <= page_i;
      hold_vld_q  <= 1'b1;
    end
  end

  assert_seq_reuse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(lookup_o) && (cyc_i == CYC_SEQ) && (page_i == $past(page_i))
    |-> use_perm_o == $past(tbl_perm_i));

  assert_nseq_fresh_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i == CYC_NSEQ) |-> use_perm_o == tbl_perm_i);

  assert_idle_no_lookup_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_access(cyc_i) |-> !lookup_o);

endmodule

// File: rtl/ppa_perm_check.sv
module ppa_perm_check
  import ppa_pkg::*;
(
  input  logic  access_i,
  input  logic  write_i,
  input  logic  priv_i,
  input  perm_t perm_i,
  output logic  abort_o,
  output logic  mem_en_o
);

  logic deny;

  assign deny     = !perm_i.valid
                 || (write_i && !perm_i.wr_ok)
                 || (!priv_i && !perm_i.usr_ok);
  assign abort_o  = access_i && deny;
  assign mem_en_o = access_i && !deny;

endmodule

// File: rtl/page_prot_abort.sv
module page_prot_abort
  import ppa_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PAGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic              priv_i,
  input  logic [1:0]        cyc_i,
  input  logic              cfg_we_i,
  input  logic [PAGE_W-1:0] cfg_idx_i,
  input  logic [2:0]        cfg_data_i,
  output logic              abort_o,
  output logic              mem_en_o
);

  logic [PAGE_W-1:0] page;
  perm_t             tbl_perm;
  perm_t             use_perm;
  perm_t             cfg_perm;
  logic              lookup;
  logic              access;

  assign page     = addr_i[ADDR_W-1 -: PAGE_W];
  assign access   = is_access(cyc_i);
  assign cfg_perm = perm_t'(cfg_data_i);

  ppa_perm_table #(.PAGE_W(PAGE_W)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (cfg_we_i),
    .wr_idx_i  (cfg_idx_i),
    .wr_perm_i (cfg_perm),
    .rd_idx_i  (page),
    .rd_perm_o (tbl_perm)
  );

  ppa_verdict_hold #(.PAGE_W(PAGE_W)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cyc_i      (cyc_i),
    .page_i     (page),
    .tbl_perm_i (tbl_perm),
    .use_perm_o (use_perm),
    .lookup_o   (lookup)
  );

  ppa_perm_check u_check (
    .access_i (access),
    .write_i  (write_i),
    .priv_i   (priv_i),
    .perm_i   (use_perm),
    .abort_o  (abort_o),
    .mem_en_o (mem_en_o)
  );

  assert_idle_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !access |-> !abort_o && !mem_en_o);

  assert_grant_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(abort_o && mem_en_o));

  assert_grant_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> use_perm.valid);

  assert_write_guard_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o && write_i |-> use_perm.wr_ok);

  assert_user_guard_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o && !priv_i |-> use_perm.usr_ok);

  assert_seq_cross_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_i == CYC_SEQ) && $past(access) && (page != $past(page)) |-> lookup);

endmodule

// File: tb/page_prot_abort_bench.sv
module page_prot_abort_bench;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        write_i = 1'b0;
  logic        priv_i = 1'b0;
  logic [1:0]  cyc_i = 2'b10;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_idx_i = '0;
  logic [2:0]  cfg_data_i = '0;
  logic        abort_o;
  logic        mem_en_o;

  int checks = 0;
  int fails = 0;

  logic [2:0] mtab [16];
  logic [2:0] mh_e;
  logic [3:0] mh_pg;
  logic       mh_v;

  always #4 clk = ~clk;

  page_prot_abort #(.ADDR_W(16), .PAGE_W(4)) u_page_prot_abort (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .write_i    (write_i),
    .priv_i     (priv_i),
    .cyc_i      (cyc_i),
    .cfg_we_i   (cfg_we_i),
    .cfg_idx_i  (cfg_idx_i),
    .cfg_data_i (cfg_data_i),
    .abort_o    (abort_o),
    .mem_en_o   (mem_en_o)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    cyc_i  = 2'b10;
    for (int i = 0; i < 16; i++) mtab[i] = 3'b000;
    mh_e = '0; mh_pg = '0; mh_v = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic prog(input logic [3:0] idx, input logic [2:0] data);
    @(negedge clk);
    cyc_i = 2'b10; cfg_we_i = 1'b1; cfg_idx_i = idx; cfg_data_i = data;
    @(posedge clk);
    #1 cfg_we_i = 1'b0;
    mtab[idx] = data;
  endtask

  task automatic acc(input logic [1:0] cy, input logic [15:0] a,
                     input logic wr, input logic pr, input string tag);
    logic [3:0] pg;
    logic [2:0] e;
    logic need, is_acc, exp_ab, exp_me;
    @(negedge clk);
    cyc_i = cy; addr_i = a; write_i = wr; priv_i = pr;
    #2;
    pg     = a[15:12];
    is_acc = (cy == 2'b00) || (cy == 2'b01);
    need   = (cy == 2'b00) || ((cy == 2'b01) && (!mh_v || pg != mh_pg));
    e      = need ? mtab[pg] : mh_e;
    exp_ab = is_acc && (!e[2] || (wr && !e[1]) || (!pr && !e[0]));
    exp_me = is_acc && !exp_ab;
    checks++;
    if (abort_o !== exp_ab || mem_en_o !== exp_me) begin
      fails++;
      $display("FAIL %s cyc=%b addr=%h wr=%b pr=%b: abort/mem_en got %b%b exp %b%b",
               tag, cy, a, wr, pr, abort_o, mem_en_o, exp_ab, exp_me);
    end
    if (need) begin
      mh_e = e; mh_pg = pg; mh_v = 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout exp completion");
    summary();
  end

  initial begin
    do_reset();
    // R1: reset state and every page aborts before programming
    acc(2'b10, 16'h0000, 1'b0, 1'b1, "R1 idle after reset");
    for (int p = 0; p < 16; p++)
      acc(2'b00, {p[3:0], 12'h3a5}, 1'b0, 1'b1, "R1");

    // R9: sequential first after reset must look up, not reuse reset hold
    do_reset();
    prog(4'd0, 3'b111);
    acc(2'b01, 16'h0010, 1'b1, 1'b0, "R9 seq after reset");

    // R2 R3 R4 R5 R10 R11: exhaustive page x encoding x dir x mode
    for (int p = 0; p < 16; p++) begin
      for (int c = 0; c < 8; c++) begin
        prog(p[3:0], c[2:0]);
        for (int wr = 0; wr < 2; wr++) begin
          for (int pr = 0; pr < 2; pr++) begin
            acc(2'b00, {p[3:0], 12'(c * 517 + wr * 33 + pr * 1001)},
                wr[0], pr[0], "R2/R3/R4/R5/R10/R11 nseq");
            acc(2'b01, {p[3:0], 12'(c * 91 + wr * 7 + pr * 2000 + 4)},
                wr[0], pr[0], "R8/R11 seq same page");
            acc(2'b10, {p[3:0], 12'h000}, wr[0], pr[0], "R6 internal");
            acc(2'b11, {p[3:0], 12'hfff}, wr[0], pr[0], "R6 coprocessor");
          end
        end
      end
    end

    // R8: rewrite after lookup, sequential same page keeps latched entry
    prog(4'd2, 3'b111);
    prog(4'd5, 3'b000);
    acc(2'b00, 16'h2000, 1'b1, 1'b0, "R7 fresh lookup");
    prog(4'd2, 3'b000);
    acc(2'b01, 16'h2004, 1'b1, 1'b0, "R8 stale entry reused");
    acc(2'b10, 16'h2008, 1'b0, 1'b0, "R6 internal between");
    acc(2'b01, 16'h2ffc, 1'b0, 1'b0, "R8 hold across internal");
    // R9: sequential into another page looks up fresh
    acc(2'b01, 16'h5000, 1'b0, 1'b1, "R9 seq cross page");
    // R7: non-sequential sees the rewrite
    acc(2'b00, 16'h2000, 1'b0, 1'b1, "R7 nseq after rewrite");
    prog(4'd2, 3'b110);
    acc(2'b01, 16'h2004, 1'b0, 1'b0, "R8 stale deny kept");
    acc(2'b00, 16'h2004, 1'b0, 1'b1, "R7 nseq new entry");
    acc(2'b01, 16'h2008, 1'b1, 1'b0, "R5 seq user denied");

    summary();
  end

endmodule